// File: doc/BRIEF.md
# LSB-First Selectable-Polynomial CRC Accumulator

This block keeps a 32-bit running CRC remainder and folds one data beat into it on every clock where a beat is presented. A beat carries 8, 16 or 32 bits, and the beat width is given with each beat. Bits go in starting from bit 0. A wide beat is treated as a run of bytes, lowest byte first. Each beat also carries a polynomial select, which picks one of three generators: the 32-bit Ethernet polynomial, the 32-bit Castagnoli polynomial, or the 16-bit CCITT polynomial. The remainder can be read on the output at any time.

The remainder is neither reflected nor inverted on its way out. A caller that wants the conventional reflected CRC-32 value reverses all 32 bits of the output and inverts them. The same conversion also works in the opposite direction. Data that another device built MSB-first has to be bit-reversed within each byte before it enters the block. A synchronous clear command puts the remainder back to all ones, so a new checksum can start. A long or scattered memory region can be covered by keeping the remainder between beats and not clearing it.

Top module: `crc_lsb_acc`

## Requirements
- R1: `poly_sel` selects the generator: 0 selects 0x04C11DB7, 1 selects 0x1EDC6F41, 2 selects 0x1021. A beat with `poly_sel` = 3 leaves the remainder unchanged.
- R2: Within a beat, bits are folded from bit 0 upward. A 16- or 32-bit beat gives the same result as the same bytes sent one at a time, lowest byte first.
- R3: After `rst`, and on the clock after `clear`, the remainder reads 0xFFFFFFFF. `clear` takes priority over a beat in the same cycle.
- R4: `beat_width` sets how many bits are folded: 0 folds 8 bits (`beat_data[7:0]`), 1 folds 16 bits, 2 folds 32 bits. A beat with `beat_width` = 3 leaves the remainder unchanged.
- R5: Each valid beat of any width is fully folded in one clock. The new remainder appears on `crc_value` after the rising edge that samples the beat.
- R6: While neither `beat_valid` nor `clear` is high, the remainder holds its value.
- R7: With the 16-bit generator, only `crc_value[15:0]` is updated, using bit 15 as the feedback tap. `crc_value[31:16]` keeps its previous value.
- R8: Changing `poly_sel` between beats applies the new generator from the next beat onward. It does not reset the remainder.
- R9: With generator 0, bit-reversing the conventional reflected CRC-32 (init and final XOR both all ones) and XORing it with 0xFFFFFFFF gives `crc_value`.
- R10: Data built MSB-first with generator 0 and all-ones init gives the same remainder if each of its bytes is bit-reversed before entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous command that restarts the checksum at all ones |
| beat_valid | input | 1 | A beat is present this cycle |
| beat_data | input | 32 | Beat payload; the low bytes are used for narrow beats |
| beat_width | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = ignored |
| poly_sel | input | 2 | Generator select (see R1) |
| crc_value | output | 32 | Running remainder, registered |

## Verification
The assertions assume that every control input is a known value at each clock edge, and that `clear` and `rst` are only ever synchronous commands. They also assume that codes 3 of `beat_width` and `poly_sel` may occur and must do nothing. The stimulus drives every input just after the falling edge, so each input is stable at the rising edge. It draws widths and selects from all four codes, so the reserved codes are exercised. It raises `clear` only now and then, sometimes in the same cycle as a beat, so the priority rule is covered.

// File: rtl/crc_lsb_pkg.sv
package crc_lsb_pkg;
  localparam int CRC_W    = 32;
  localparam int NARROW_W = 16;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {
    GEN_ETH32  = 2'd0,
    GEN_CAST32 = 2'd1,
    GEN_CCITT  = 2'd2,
    GEN_NONE   = 2'd3
  } gen_sel_e;

  typedef enum logic [1:0] {
    BW_BYTE = 2'd0,
    BW_HALF = 2'd1,
    BW_WORD = 2'd2,
    BW_NONE = 2'd3
  } beat_w_e;

  localparam logic [CRC_W-1:0] POLY_ETH32  = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] POLY_CAST32 = 32'h1EDC_6F41;
  localparam logic [CRC_W-1:0] POLY_CCITT  = 32'h0000_1021;
  localparam logic [CRC_W-1:0] SEED        = 32'hFFFF_FFFF;
endpackage

// File: rtl/crc_gen_lut.sv
module crc_gen_lut
  import crc_lsb_pkg::*;
(
  input  logic [1:0]       sel_i,
  output logic [CRC_W-1:0] poly_o,
  output logic             narrow_o,
  output logic             known_o
);
  always_comb begin
    poly_o   = '0;
    narrow_o = 1'b0;
    known_o  = 1'b1;
    unique case (gen_sel_e'(sel_i))
      GEN_ETH32:  poly_o = POLY_ETH32;
      GEN_CAST32: poly_o = POLY_CAST32;
      GEN_CCITT: begin
        poly_o   = POLY_CCITT;
        narrow_o = 1'b1;
      end
      default:    known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crc_byte_fold.sv
module crc_byte_fold #(
  parameter int CRC_W    = 32,
  parameter int NARROW_W = 16,
  parameter int BYTE_W   = 8
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CRC_W-1:0]  poly_i,
  input  logic              narrow_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = crc_i;
    fb  = 1'b0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (narrow_i) begin
        fb = acc[NARROW_W-1] ^ byte_i[i];
        acc[NARROW_W-1:0] = {acc[NARROW_W-2:0], 1'b0}
                            ^ (fb ? poly_i[NARROW_W-1:0] : '0);
      end else begin
        fb  = acc[CRC_W-1] ^ byte_i[i];
        acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly_i : '0);
      end
    end
    crc_o = acc;
  end
endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg #(
  parameter int              CRC_W = 32,
  parameter logic [CRC_W-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i)  q_o <= INIT;
    else if (load_i)     q_o <= next_i;
  end
endmodule

// File: rtl/crc_lsb_acc.sv
module crc_lsb_acc
  import crc_lsb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [1:0]        beat_width,
  input  logic [1:0]        poly_sel,
  output logic [CRC_W-1:0]  crc_value
);
  localparam int LANES = DATA_W / BYTE_W;

  logic [CRC_W-1:0] poly;
  logic             narrow, known, width_ok, load;
  logic [CRC_W-1:0] stage [LANES+1];
  logic [CRC_W-1:0] next_rem;

  crc_gen_lut u_lut (
    .sel_i   (poly_sel),
    .poly_o  (poly),
    .narrow_o(narrow),
    .known_o (known)
  );

  assign stage[0] = crc_value;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    crc_byte_fold #(.CRC_W(CRC_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_fold (
      .crc_i   (stage[k]),
      .byte_i  (beat_data[k*BYTE_W +: BYTE_W]),
      .poly_i  (poly),
      .narrow_i(narrow),
      .crc_o   (stage[k+1])
    );
  end

  always_comb begin
    width_ok = 1'b1;
    next_rem = crc_value;
    unique case (beat_w_e'(beat_width))
      BW_BYTE: next_rem = stage[1];
      BW_HALF: next_rem = stage[2];
      BW_WORD: next_rem = stage[LANES];
      default: width_ok = 1'b0;
    endcase
  end

  assign load = beat_valid & known & width_ok;

  crc_rem_reg #(.CRC_W(CRC_W), .INIT(SEED)) u_rem (
    .clk    (clk),
    .rst    (rst),
    .clear_i(clear),
    .load_i (load),
    .next_i (next_rem),
    .q_o    (crc_value)
  );
endmodule

// File: rtl/crc_lsb_acc_chk.sv
module crc_lsb_acc_chk (
  input logic        clk,
  input logic        rst,
  input logic        clear,
  input logic        beat_valid,
  input logic [1:0]  beat_width,
  input logic [1:0]  poly_sel,
  input logic [31:0] crc_value
);
  AST_CLEAR_SEEDS: assert property (@(posedge clk) disable iff (rst)
    clear |=> crc_value == 32'hFFFF_FFFF); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!beat_valid && !clear) |=> $stable(crc_value)); // R6
  AST_RESERVED_GEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !clear && poly_sel == 2'd3) |=> $stable(crc_value)); // R1
  AST_RESERVED_WIDTH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !clear && beat_width == 2'd3) |=> $stable(crc_value)); // R4
  AST_NARROW_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !clear && poly_sel == 2'd2) |=> $stable(crc_value[31:16])); // R7
endmodule

bind crc_lsb_acc crc_lsb_acc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .beat_valid(beat_valid),
  .beat_width(beat_width),
  .poly_sel  (poly_sel),
  .crc_value (crc_value)
);

// File: tb/crc_lsb_acc_tb.sv
module crc_lsb_acc_tb;
  logic        clk = 1'b0;
  logic        rst, clear, beat_valid;
  logic [31:0] beat_data;
  logic [1:0]  beat_width, poly_sel;
  logic [31:0] crc_value;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crc_lsb_acc u_dut (.*);

  function automatic logic [31:0] m_step(logic [31:0] c, logic [31:0] d,
                                         logic [1:0] w, logic [1:0] s);
    int n;
    logic fb;
    logic [31:0] p;
    n = (w == 0) ? 8 : (w == 1) ? 16 : (w == 2) ? 32 : 0;
    if (s == 3) return c;
    p = (s == 0) ? 32'h04C11DB7 : (s == 1) ? 32'h1EDC6F41 : 32'h1021;
    for (int i = 0; i < n; i++) begin
      if (s == 2) begin
        fb = c[15] ^ d[i];
        c[15:0] = {c[14:0], 1'b0} ^ (fb ? p[15:0] : 16'h0);
      end else begin
        fb = c[31] ^ d[i];
        c = {c[30:0], 1'b0} ^ (fb ? p : 32'h0);
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] rev32(logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic beat(logic [31:0] d, logic [1:0] w, logic [1:0] s);
    beat_valid = 1; beat_data = d; beat_width = w; poly_sel = s;
    @(negedge clk);
    beat_valid = 0;
  endtask

  task automatic do_clear();
    clear = 1;
    @(negedge clk);
    clear = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] model, sw, held, msb;
    logic [7:0] msg [9];
    void'($urandom(32'h5eed_c0de));
    rst = 1; clear = 0; beat_valid = 0; beat_data = 0; beat_width = 0; poly_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R3 reset value", crc_value, 32'hFFFFFFFF);

    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    // R9: conventional reflected CRC-32, converted
    sw = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) begin
      sw ^= {24'h0, msg[i]};
      for (int b = 0; b < 8; b++) sw = sw[0] ? ((sw >> 1) ^ 32'hEDB88320) : (sw >> 1);
    end
    sw ^= 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) beat({24'h0, msg[i]}, 2'd0, 2'd0);
    chk("R9 byte beats vs reflected CRC-32", crc_value, rev32(sw) ^ 32'hFFFFFFFF);
    chk("R9 known vector", crc_value, 32'h9B63D02C);

    // R2/R4: word and halfword packing, lowest byte first
    do_clear();
    beat(32'h34333231, 2'd2, 2'd0);
    beat(32'h00003635, 2'd1, 2'd0);
    beat(32'h00003837, 2'd1, 2'd0);
    beat(32'hAAAAAA39, 2'd0, 2'd0);
    chk("R2 mixed-width packing", crc_value, 32'h9B63D02C);

    // R5: one-beat latency
    do_clear();
    beat(32'hDEADBEEF, 2'd2, 2'd1);
    chk("R5 single word Castagnoli", crc_value, m_step(32'hFFFFFFFF, 32'hDEADBEEF, 2, 1));

    // R6: hold when idle
    held = crc_value;
    repeat (5) @(negedge clk);
    chk("R6 idle hold", crc_value, held);

    // R1/R4: reserved codes ignored
    beat(32'h12345678, 2'd2, 2'd3);
    chk("R1 reserved generator ignored", crc_value, held);
    beat(32'h12345678, 2'd3, 2'd0);
    chk("R4 reserved width ignored", crc_value, held);

    // R7: narrow generator keeps upper half
    beat(32'h0000A55A, 2'd1, 2'd2);
    chk("R7 upper half held", {16'h0, crc_value[31:16]}, {16'h0, held[31:16]});
    chk("R7 low half update", crc_value, m_step(held, 32'h0000A55A, 1, 2));

    // R8: switch generator without reset
    model = crc_value;
    beat(32'h0F1E2D3C, 2'd2, 2'd0);
    model = m_step(model, 32'h0F1E2D3C, 2, 0);
    chk("R8 switch narrow to Ethernet", crc_value, model);
    beat(32'h000000C3, 2'd0, 2'd1);
    model = m_step(model, 32'h000000C3, 0, 1);
    chk("R8 switch to Castagnoli", crc_value, model);

    // R3: clear wins over a simultaneous beat
    clear = 1;
    beat(32'hFFFF0000, 2'd2, 2'd0);
    clear = 0;
    chk("R3 clear priority", crc_value, 32'hFFFFFFFF);

    // R10: MSB-first producer with per-byte reversal
    msb = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = msb[31] ^ msg[i][b];
        msb = {msb[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    for (int i = 0; i < 9; i++) beat({24'h0, rev8(msg[i])}, 2'd0, 2'd0);
    chk("R10 MSB-first with byte reversal", crc_value, msb);

    // Random mix: R1 R2 R4 R5 R7 R8 R3
    do_clear();
    model = 32'hFFFFFFFF;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] d;
      logic [1:0] w, s;
      logic v, c;
      d = $urandom; w = 2'($urandom); s = 2'($urandom);
      v = ($urandom % 4) != 0; c = ($urandom % 40) == 0;
      beat_valid = v; beat_data = d; beat_width = w; poly_sel = s; clear = c;
      @(negedge clk);
      beat_valid = 0; clear = 0;
      if (c) model = 32'hFFFFFFFF;
      else if (v) model = m_step(model, d, w, s);
      chk("R5 random stream", crc_value, model);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule